// File: doc/BRIEF.md
# Memory-Mapped Address Window Bridge

The bridge connects a host that only drives a narrow byte address to a memory that needs a wider one. Every read or write arriving on the window port leaves on the expanded port with a window base in front of the incoming address. Data, byte enables, wait-request, read data and read-valid are not touched. The host therefore sees a 2 GB aperture into a 4 GB space.

The window base resets to a parameter value. With the control port enabled (`CTRL_EN = 1`), software can read and rewrite the base through a single 32-bit register, which lets it step the aperture across the whole expanded space. With the control port disabled, the base never moves.

The bridge tracks a single transaction at a time. A base write that lands while a window command is stalled, or while a read is waiting for its data, is parked. It is applied on the first clock edge at which nothing is in flight, so an access never splits across two bases.

Top module: `addr_window_bridge`

## Requirements
- R1: `exp_addr_o` equals the window base plus zero-extended `win_addr_i`, truncated to 32 bits, in the same cycle as `win_addr_i`. The base is always a multiple of 2^31, so the sum is `{base[31], win_addr_i}`.
- R2: `exp_read_o`, `exp_write_o`, `exp_wdata_o` and `exp_be_o` equal `win_read_i`, `win_write_i`, `win_wdata_i` and `win_be_i` in the same cycle.
- R3: `win_wait_o`, `win_rdata_o` and `win_rvalid_o` equal `exp_wait_i`, `exp_rdata_i` and `exp_rvalid_i` in the same cycle.
- R4: After reset, the window base is `BASE_RST` with its low 31 bits cleared, and no transaction is pending.
- R5: A control read (`csr_read_i` high for one cycle) raises `csr_rvalid_o` on the next cycle, with `csr_rdata_o` holding the base as it was in the read cycle. Bits 30:0 of `csr_rdata_o` always read 0. A control write with nothing in flight updates the base at that clock edge from `csr_wdata_i[31]`, and bits 30:0 of the write data are ignored.
- R6: The bridge is busy in these cases:
  - a window read is presented;
  - a window write is presented while `exp_wait_i` is high;
  - a read has been accepted and its read-valid has not yet arrived.
  
  A control write made while busy leaves the base unchanged. The parked value is applied at the first clock edge at which the bridge is not busy.
- R7: When several control writes are parked during one busy period, the last one is the one applied.
- R8: With `CTRL_EN = 0`, the base stays at `BASE_RST`. Control writes have no effect, and `csr_rvalid_o` and `csr_rdata_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_addr_i | input | 31 | Window byte address |
| win_read_i | input | 1 | Window read command |
| win_write_i | input | 1 | Window write command |
| win_wdata_i | input | 32 | Window write data |
| win_be_i | input | 4 | Window byte enables |
| win_rdata_o | output | 32 | Read data to host |
| win_rvalid_o | output | 1 | Read data valid to host |
| win_wait_o | output | 1 | Wait-request to host |
| exp_addr_o | output | 32 | Expanded byte address |
| exp_read_o | output | 1 | Expanded read command |
| exp_write_o | output | 1 | Expanded write command |
| exp_wdata_o | output | 32 | Expanded write data |
| exp_be_o | output | 4 | Expanded byte enables |
| exp_rdata_i | input | 32 | Read data from memory |
| exp_rvalid_i | input | 1 | Read data valid from memory |
| exp_wait_i | input | 1 | Wait-request from memory |
| csr_read_i | input | 1 | Control register read |
| csr_write_i | input | 1 | Control register write |
| csr_wdata_i | input | 32 | Control write data (new base) |
| csr_rdata_o | output | 32 | Control read data (current base) |
| csr_rvalid_o | output | 1 | Control read data valid |

## Verification
The pass-through and address results (R1 to R3) are combinational, so the bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. Control reads are due one cycle later, and the bench samples them on the following falling edge. Base updates appear only after the rising edge that commits them. For each deferral case (R6, R7), the bench checks that the old base is still visible on every busy cycle, then checks the new base on the falling edge just after the first edge at which the bridge is idle.

// File: rtl/awb_pkg.sv
package awb_pkg;
  localparam int unsigned AWB_WIN_AW = 31;
  localparam int unsigned AWB_EXP_AW = 32;
  localparam int unsigned AWB_DW     = 32;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_CSR  = 2'd1,
    UPD_PEND = 2'd2
  } upd_sel_e;
endpackage

// File: rtl/awb_txn_track.sv
module awb_txn_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_rd_i,
  input  logic cmd_wr_i,
  input  logic wait_i,
  input  logic rvalid_i,
  output logic rd_out_o,
  output logic busy_o
);
  logic rd_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_out_q <= 1'b0;
    else if (cmd_rd_i && !wait_i) rd_out_q <= 1'b1;
    else if (rvalid_i)          rd_out_q <= 1'b0;
  end

  // a read stays in flight from presentation until its data returns
  assign busy_o   = cmd_rd_i | (cmd_wr_i & wait_i) | (rd_out_q & ~rvalid_i);
  assign rd_out_o = rd_out_q;
endmodule

// File: rtl/awb_base_reg.sv
module awb_base_reg
  import awb_pkg::*;
#(
  parameter int unsigned          EXP_AW   = AWB_EXP_AW,
  parameter int unsigned          WIN_AW   = AWB_WIN_AW,
  parameter logic [EXP_AW-1:0]    BASE_RST = '0,
  parameter bit                   CTRL_EN  = 1'b1,
  localparam int unsigned         HI_W     = EXP_AW - WIN_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              csr_wr_i,
  input  logic [EXP_AW-1:0] csr_wdata_i,
  output logic [HI_W-1:0]   base_hi_o
);
  localparam logic [HI_W-1:0] RST_HI = BASE_RST[EXP_AW-1:WIN_AW];

  if (CTRL_EN) begin : g_prog
    logic [HI_W-1:0] base_q, pend_q;
    logic            pend_v_q;
    upd_sel_e        sel;
    logic [WIN_AW-1:0] unused_lo;
    assign unused_lo = csr_wdata_i[WIN_AW-1:0];

    always_comb begin
      if (!busy_i && csr_wr_i)      sel = UPD_CSR;
      else if (!busy_i && pend_v_q) sel = UPD_PEND;
      else                          sel = UPD_HOLD;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q   <= RST_HI;
        pend_q   <= '0;
        pend_v_q <= 1'b0;
      end else begin
        unique case (sel)
          UPD_CSR: begin
            base_q   <= csr_wdata_i[EXP_AW-1:WIN_AW];
            pend_v_q <= 1'b0;
          end
          UPD_PEND: begin
            base_q   <= pend_q;
            pend_v_q <= 1'b0;
          end
          default: begin
            // park the newest write until the bridge goes idle
            if (csr_wr_i) begin
              pend_q   <= csr_wdata_i[EXP_AW-1:WIN_AW];
              pend_v_q <= 1'b1;
            end
          end
        endcase
      end
    end
    assign base_hi_o = base_q;
  end else begin : g_fixed
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, busy_i, csr_wr_i, csr_wdata_i};
    assign base_hi_o = RST_HI;
  end
endmodule

// File: rtl/awb_csr_read.sv
module awb_csr_read #(
  parameter int unsigned EXP_AW  = 32,
  parameter int unsigned WIN_AW  = 31,
  parameter bit          CTRL_EN = 1'b1,
  localparam int unsigned HI_W   = EXP_AW - WIN_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_rd_i,
  input  logic [HI_W-1:0]   base_hi_i,
  output logic [EXP_AW-1:0] rdata_o,
  output logic              rvalid_o
);
  if (CTRL_EN) begin : g_rd
    logic [EXP_AW-1:0] rdata_q;
    logic              rvalid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_q  <= '0;
        rvalid_q <= 1'b0;
      end else begin
        rvalid_q <= csr_rd_i;
        if (csr_rd_i) rdata_q <= {base_hi_i, {WIN_AW{1'b0}}};
      end
    end
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
  end else begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, csr_rd_i, base_hi_i};
    assign rdata_o   = '0;
    assign rvalid_o  = 1'b0;
  end
endmodule

// File: rtl/addr_window_bridge.sv
module addr_window_bridge
  import awb_pkg::*;
#(
  parameter int unsigned       WIN_AW   = AWB_WIN_AW,
  parameter int unsigned       EXP_AW   = AWB_EXP_AW,
  parameter int unsigned       DW       = AWB_DW,
  parameter logic [EXP_AW-1:0] BASE_RST = 32'h8000_0000,
  parameter bit                CTRL_EN  = 1'b1,
  localparam int unsigned      BEW      = DW / 8,
  localparam int unsigned      HI_W     = EXP_AW - WIN_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_AW-1:0] win_addr_i,
  input  logic              win_read_i,
  input  logic              win_write_i,
  input  logic [DW-1:0]     win_wdata_i,
  input  logic [BEW-1:0]    win_be_i,
  output logic [DW-1:0]     win_rdata_o,
  output logic              win_rvalid_o,
  output logic              win_wait_o,
  output logic [EXP_AW-1:0] exp_addr_o,
  output logic              exp_read_o,
  output logic              exp_write_o,
  output logic [DW-1:0]     exp_wdata_o,
  output logic [BEW-1:0]    exp_be_o,
  input  logic [DW-1:0]     exp_rdata_i,
  input  logic              exp_rvalid_i,
  input  logic              exp_wait_i,
  input  logic              csr_read_i,
  input  logic              csr_write_i,
  input  logic [EXP_AW-1:0] csr_wdata_i,
  output logic [EXP_AW-1:0] csr_rdata_o,
  output logic              csr_rvalid_o
);
  logic            rd_out, busy;
  logic [HI_W-1:0] base_hi;

  awb_txn_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_rd_i (win_read_i),
    .cmd_wr_i (win_write_i),
    .wait_i   (exp_wait_i),
    .rvalid_i (exp_rvalid_i),
    .rd_out_o (rd_out),
    .busy_o   (busy)
  );

  awb_base_reg #(
    .EXP_AW(EXP_AW), .WIN_AW(WIN_AW), .BASE_RST(BASE_RST), .CTRL_EN(CTRL_EN)
  ) u_base (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .csr_wr_i    (csr_write_i),
    .csr_wdata_i (csr_wdata_i),
    .base_hi_o   (base_hi)
  );

  awb_csr_read #(
    .EXP_AW(EXP_AW), .WIN_AW(WIN_AW), .CTRL_EN(CTRL_EN)
  ) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csr_rd_i  (csr_read_i),
    .base_hi_i (base_hi),
    .rdata_o   (csr_rdata_o),
    .rvalid_o  (csr_rvalid_o)
  );

  // aligned base: the add reduces to a concatenation
  assign exp_addr_o   = {base_hi, win_addr_i};
  assign exp_read_o   = win_read_i;
  assign exp_write_o  = win_write_i;
  assign exp_wdata_o  = win_wdata_i;
  assign exp_be_o     = win_be_i;
  assign win_rdata_o  = exp_rdata_i;
  assign win_rvalid_o = exp_rvalid_i;
  assign win_wait_o   = exp_wait_i;
endmodule

// File: rtl/awb_chk.sv
module awb_chk #(
  parameter int unsigned       WIN_AW   = 31,
  parameter int unsigned       EXP_AW   = 32,
  parameter logic [EXP_AW-1:0] BASE_RST = '0,
  parameter bit                CTRL_EN  = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WIN_AW-1:0] win_addr_i,
  input logic              win_read_i,
  input logic              win_write_i,
  input logic              exp_wait_i,
  input logic              exp_rvalid_i,
  input logic [EXP_AW-1:0] exp_addr_o,
  input logic              csr_read_i,
  input logic [EXP_AW-1:0] csr_rdata_o,
  input logic              csr_rvalid_o,
  input logic              rd_out
);
  // R6
  stall_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((win_read_i || win_write_i) && exp_wait_i) ##1
    ((win_read_i || win_write_i) && $stable(win_addr_i)) |-> $stable(exp_addr_o));

  // R6
  rd_out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_out && !exp_rvalid_i) |=> $stable(exp_addr_o[EXP_AW-1:WIN_AW]));

  // R5
  csr_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CTRL_EN && csr_read_i) |=> csr_rvalid_o);

  // R5
  csr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rvalid_o |-> (csr_rdata_o[WIN_AW-1:0] == '0));

  // R8
  fixed_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !CTRL_EN |-> (exp_addr_o[EXP_AW-1:WIN_AW] == BASE_RST[EXP_AW-1:WIN_AW]
                  && !csr_rvalid_o));
endmodule

bind addr_window_bridge awb_chk #(
  .WIN_AW(WIN_AW), .EXP_AW(EXP_AW), .BASE_RST(BASE_RST), .CTRL_EN(CTRL_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_addr_i   (win_addr_i),
  .win_read_i   (win_read_i),
  .win_write_i  (win_write_i),
  .exp_wait_i   (exp_wait_i),
  .exp_rvalid_i (exp_rvalid_i),
  .exp_addr_o   (exp_addr_o),
  .csr_read_i   (csr_read_i),
  .csr_rdata_o  (csr_rdata_o),
  .csr_rvalid_o (csr_rvalid_o),
  .rd_out       (rd_out)
);

// File: tb/addr_window_bridge_tb.sv
`timescale 1ns/1ps
module addr_window_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [30:0] win_addr = '0;
  logic        win_rd = 1'b0, win_wr = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [3:0]  win_be = '0;
  logic [31:0] exp_rdata = '0;
  logic        exp_rvalid = 1'b0, exp_wait = 1'b0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;

  logic [31:0] d_rdata, d_addr, d_wdata, d_csr_rdata;
  logic        d_rvalid, d_wait, d_rd, d_wr, d_csr_rvalid;
  logic [3:0]  d_be;
  logic [31:0] f_rdata, f_addr, f_wdata, f_csr_rdata;
  logic        f_rvalid, f_wait, f_rd, f_wr, f_csr_rvalid;
  logic [3:0]  f_be;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_window_bridge #(.BASE_RST(32'h8000_0000), .CTRL_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .win_addr_i(win_addr), .win_read_i(win_rd),
    .win_write_i(win_wr), .win_wdata_i(win_wdata), .win_be_i(win_be),
    .win_rdata_o(d_rdata), .win_rvalid_o(d_rvalid), .win_wait_o(d_wait),
    .exp_addr_o(d_addr), .exp_read_o(d_rd), .exp_write_o(d_wr),
    .exp_wdata_o(d_wdata), .exp_be_o(d_be), .exp_rdata_i(exp_rdata),
    .exp_rvalid_i(exp_rvalid), .exp_wait_i(exp_wait), .csr_read_i(csr_rd),
    .csr_write_i(csr_wr), .csr_wdata_i(csr_wdata), .csr_rdata_o(d_csr_rdata),
    .csr_rvalid_o(d_csr_rvalid));

  addr_window_bridge #(.BASE_RST(32'h0000_0000), .CTRL_EN(1'b0)) u_dut_fixed (
    .clk_i(clk), .rst_ni(rst_ni), .win_addr_i(win_addr), .win_read_i(win_rd),
    .win_write_i(win_wr), .win_wdata_i(win_wdata), .win_be_i(win_be),
    .win_rdata_o(f_rdata), .win_rvalid_o(f_rvalid), .win_wait_o(f_wait),
    .exp_addr_o(f_addr), .exp_read_o(f_rd), .exp_write_o(f_wr),
    .exp_wdata_o(f_wdata), .exp_be_o(f_be), .exp_rdata_i(exp_rdata),
    .exp_rvalid_i(exp_rvalid), .exp_wait_i(exp_wait), .csr_read_i(csr_rd),
    .csr_write_i(csr_wr), .csr_wdata_i(csr_wdata), .csr_rdata_o(f_csr_rdata),
    .csr_rvalid_o(f_csr_rvalid));

  function automatic logic [31:0] xlate(input logic [31:0] base, input logic [30:0] a);
    return base + {1'b0, a};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic idle();
    win_rd = 0; win_wr = 0; exp_wait = 0; exp_rvalid = 0; csr_rd = 0; csr_wr = 0;
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base_m;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_ni = 1'b1;

    // R4: reset base
    base_m = 32'h8000_0000;
    win_addr = 31'h0000_1234; #1;
    chk("R4", "addr after reset", d_addr, 32'h8000_1234);
    step(); csr_rd = 1; step(); csr_rd = 0; #1;
    chk("R4", "csr rvalid", {31'd0, d_csr_rvalid}, 32'd1);
    chk("R4", "csr rdata", d_csr_rdata, 32'h8000_0000);

    // R1 R2 R3 R8: random pass-through traffic
    for (int i = 0; i < 300; i++) begin
      step();
      win_addr = 31'($urandom); win_rd = 1'($urandom); win_wr = 1'($urandom);
      win_wdata = $urandom; win_be = 4'($urandom); exp_rdata = $urandom;
      exp_rvalid = 1'($urandom); exp_wait = 1'($urandom);
      #1;
      chk("R1", "exp_addr", d_addr, xlate(base_m, win_addr));
      chk("R2", "cmd/be", {26'd0, d_rd, d_wr, d_be}, {26'd0, win_rd, win_wr, win_be});
      chk("R2", "wdata", d_wdata, win_wdata);
      chk("R3", "rdata", d_rdata, exp_rdata);
      chk("R3", "rvalid/wait", {30'd0, d_rvalid, d_wait}, {30'd0, exp_rvalid, exp_wait});
      chk("R8", "fixed addr", f_addr, xlate(32'h0, win_addr));
    end
    step(); idle(); exp_rvalid = 1; step(); exp_rvalid = 0; step();

    // R5: idle writes, low bits ignored
    csr_wr = 1; csr_wdata = 32'h0000_0000; #1;
    chk("R5", "write not before edge", d_addr, xlate(32'h8000_0000, win_addr));
    step(); csr_wr = 0; base_m = 32'h0; #1;
    chk("R5", "write applied", d_addr, xlate(base_m, win_addr));
    step(); csr_wr = 1; csr_wdata = 32'h8123_4567;
    step(); csr_wr = 0; base_m = 32'h8000_0000; #1;
    chk("R5", "low bits ignored", d_addr, xlate(base_m, win_addr));
    csr_rd = 1; step(); csr_rd = 0; #1;
    chk("R5", "csr read aligned", d_csr_rdata, 32'h8000_0000);
    chk("R8", "fixed addr after writes", f_addr, xlate(32'h0, win_addr));
    chk("R8", "fixed csr rvalid", {31'd0, f_csr_rvalid}, 32'd0);

    // R6: write during stalled read, then outstanding read
    step(); win_rd = 1; exp_wait = 1; csr_wr = 1; csr_wdata = 32'h0;
    step(); csr_wr = 0; csr_rd = 1; #1;
    chk("R6", "stalled read keeps base", d_addr, xlate(32'h8000_0000, win_addr));
    step(); csr_rd = 0; exp_wait = 0; #1;
    chk("R6", "csr read during defer", d_csr_rdata, 32'h8000_0000);
    step(); win_rd = 0; #1;
    chk("R6", "outstanding read keeps base", d_addr, xlate(32'h8000_0000, win_addr));
    step(); #1;
    chk("R6", "still outstanding", d_addr, xlate(32'h8000_0000, win_addr));
    exp_rvalid = 1; exp_rdata = 32'hCAFE_F00D; #0.5;
    chk("R3", "read return", d_rdata, 32'hCAFE_F00D);
    step(); exp_rvalid = 0; base_m = 32'h0; #1;
    chk("R6", "deferred applied", d_addr, xlate(base_m, win_addr));

    // R7: two writes parked during stalled write; last wins
    step(); win_wr = 1; exp_wait = 1; csr_wr = 1; csr_wdata = 32'h0000_0000;
    step(); csr_wdata = 32'h8000_0000;
    step(); csr_wr = 0; #1;
    chk("R7", "stalled write keeps base", d_addr, xlate(32'h0, win_addr));
    exp_wait = 0;
    step(); win_wr = 0; base_m = 32'h8000_0000; #1;
    chk("R7", "last parked write applied", d_addr, xlate(base_m, win_addr));
    win_addr = 31'h7FFF_FFFF; #1;
    chk("R1", "top of window", d_addr, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule